// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes a 4-bit condition selector and the four stored arithmetic flags: negative (N), zero (Z), overflow (V) and carry (C). From these it produces one taken bit. The selector space holds four kinds of test:

- signed relations, which use N, V and Z;
- unsigned relations, which use C and Z;
- direct tests of a single flag;
- the constant conditions always and never.

Bit 3 of the selector is a polarity bit. Each code with bit 3 set is the logical complement of the code with bit 3 clear. The decode therefore only has to compute eight base predicates.

The decision logic is purely combinational. A thin registered stage sits around it. When the caller raises a strobe, that stage samples the selector and the flags at the clock edge. On the next cycle it presents the decision together with a valid bit. Carry-set and carry-clear are not separate codes: they are the unsigned less-than and unsigned greater-or-equal codes.

Top module: `branch_cond_unit`

## Requirements
- R1: For any flag values, selector codes s and s+8 (s in 0..7) give opposite taken results.
- R2: Signed relations are decided as follows:
  - code 3 (less-than) is taken when N xor V is 1;
  - code 2 (less-or-equal) is taken when Z or (N xor V) is 1;
  - code 11 (greater-or-equal) is taken when N xor V is 0;
  - code 10 (greater-than) is taken when Z or (N xor V) is 0.
- R3: Code 1 (equal) is taken when Z is 1; code 9 (not-equal) is taken when Z is 0.
- R4: Unsigned relations are decided as follows:
  - code 5 (less-than, also carry-set) is taken when C is 1;
  - code 4 (less-or-equal) is taken when Z or C is 1;
  - code 13 (greater-or-equal, also carry-clear) is taken when C is 0;
  - code 12 (greater-than) is taken only when both Z and C are 0.
- R5: Direct flag tests are decided as follows:
  - code 6 (negative) is taken when N is 1;
  - code 14 (positive) is taken when N is 0;
  - code 7 (overflow set) is taken when V is 1;
  - code 15 (overflow clear) is taken when V is 0.
- R6: Code 8 (always) is taken for every flag value; code 0 (never) is taken for none.
- R7: `out_valid` is high in exactly the cycle after a clock edge at which `in_valid` was high. `out_taken` then reflects the selector and flags sampled at that edge.
- R8: While `out_valid` is low, `out_taken` is 0, whatever the selector and flags are.
- R9: A clock edge with `rst_n` low clears `out_valid` and `out_taken`, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: sample selector and flags this edge |
| cond_sel | input | 4 | Condition selector code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Decision present this cycle |
| out_taken | output | 1 | Branch taken decision, 0 when not valid |

## Verification
The hardest case to reach from the ports is the polarity pairing of R1. It needs the same flag vector presented under two selectors eight codes apart, with the two registered results held side by side. The stimulus sweeps all 256 selector and flag pairs through the strobe. It stores each registered result by selector and flags, and after the sweep it compares every complementary pair. Idle cycles with the always code and true flags applied, and a reset asserted while the strobe is high, cover R8 and R9.

// File: rtl/bce_pkg.sv
// Package: shared types and widths for the branch condition evaluator.
// Assumes flags arrive already stored from a previous arithmetic operation.
package bce_pkg;
    localparam int SEL_W   = 4;
    localparam int BASE_W  = SEL_W - 1;
    localparam int POL_BIT = SEL_W - 1;

    // Base predicates; selector bit POL_BIT inverts each one.
    typedef enum logic [BASE_W-1:0] {
        BASE_NEVER = 3'd0,
        BASE_EQ    = 3'd1,
        BASE_SLE   = 3'd2,
        BASE_SLT   = 3'd3,
        BASE_ULE   = 3'd4,
        BASE_ULT   = 3'd5,
        BASE_NEG   = 3'd6,
        BASE_VS    = 3'd7
    } base_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam logic [SEL_W-1:0] COND_NEVER  = 4'd0;
    localparam logic [SEL_W-1:0] COND_EQ     = 4'd1;
    localparam logic [SEL_W-1:0] COND_ALWAYS = 4'd8;
endpackage

// File: rtl/bce_relation.sv
// Module: computes one of eight base predicates from the stored flags.
// Assumes the base code is the selector with its polarity bit removed.
module bce_relation
    import bce_pkg::*;
(
    input  base_e  base,
    input  flags_t flags,
    output logic   hit
);
    logic signed_lt;
    logic unsigned_lt;

    // Shared relation terms for the signed and unsigned groups.
    always_comb begin
        signed_lt   = flags.n ^ flags.v;
        unsigned_lt = flags.c;
    end

    // Pick the requested base predicate.
    always_comb begin
        unique case (base)
            BASE_NEVER: hit = 1'b0;
            BASE_EQ:    hit = flags.z;
            BASE_SLE:   hit = flags.z | signed_lt;
            BASE_SLT:   hit = signed_lt;
            BASE_ULE:   hit = flags.z | unsigned_lt;
            BASE_ULT:   hit = unsigned_lt;
            BASE_NEG:   hit = flags.n;
            BASE_VS:    hit = flags.v;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bce_eval.sv
// Module: combinational branch decision for a full selector code.
// Assumes selector bit POL_BIT marks the complementary condition.
module bce_eval
    import bce_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  flags_t           flags,
    output logic             taken
);
    base_e base;
    logic  base_hit;

    // Strip the polarity bit to get the base predicate code.
    always_comb base = base_e'(sel[BASE_W-1:0]);

    bce_relation u_rel (
        .base  (base),
        .flags (flags),
        .hit   (base_hit)
    );

    // Apply polarity: the upper half of the code space is inverted.
    always_comb taken = base_hit ^ sel[POL_BIT];
endmodule

// File: rtl/branch_cond_unit.sv
// Module: registered branch condition evaluator.
// Samples the selector and flags on a strobe and presents taken/valid
// one cycle later. Synchronous active-low reset. Taken is forced low
// whenever valid is low.
module branch_cond_unit
    import bce_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_v,
    input  logic             flag_c,
    output logic             out_valid,
    output logic             out_taken
);
    flags_t flags;
    logic   decide;

    // Gather the flag pins into one record.
    always_comb flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bce_eval u_eval (
        .sel   (cond_sel),
        .flags (flags),
        .taken (decide)
    );

    // Output stage: capture the strobe and the gated decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_taken <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_taken <= in_valid & decide;
        end
    end

    // R7
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    taken_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_taken);

    // R6
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == COND_ALWAYS) |=> out_taken);

    // R6
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == COND_NEVER) |=> !out_taken);

    // R3
    equal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_sel == COND_EQ) |=> (out_taken == $past(flag_z)));
endmodule

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] cond_sel = 4'd0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
    logic       out_valid, out_taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    bit ev = 0, et = 0;
    int esel = 0, eflg = 0;
    bit res [16][16];
    bit seen [16][16];

    always #5 clk = ~clk;

    branch_cond_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .out_valid(out_valid), .out_taken(out_taken)
    );

    function automatic bit ref_taken(int s, bit n, bit z, bit v, bit c);
        case (s)
            0:  return 0;                 // R6 never
            1:  return z;                 // R3
            2:  return z || (n != v);     // R2
            3:  return n != v;            // R2
            4:  return z || c;            // R4
            5:  return c;                 // R4
            6:  return n;                 // R5
            7:  return v;                 // R5
            8:  return 1;                 // R6 always
            9:  return !z;                // R3
            10: return !(z || (n != v));  // R2
            11: return n == v;            // R2
            12: return !z && !c;          // R4
            13: return !c;                // R4
            14: return !n;                // R5
            default: return !v;           // R5
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            0, 8:          return "R6";
            1, 9:          return "R3";
            2, 3, 10, 11:  return "R2";
            4, 5, 12, 13:  return "R4";
            default:       return "R5";
        endcase
    endfunction

    // Model: one register stage, reset clears it (R9), gated taken (R8)
    always @(posedge clk) begin
        if (!rst_n) begin
            ev <= 0; et <= 0;
        end else begin
            ev   <= in_valid;
            et   <= in_valid && ref_taken(cond_sel, flag_n, flag_z, flag_v, flag_c);
            esel <= cond_sel;
            eflg <= {flag_n, flag_z, flag_v, flag_c};
        end
    end

    // Compare every cycle, away from the edge
    always @(posedge clk) begin
        #3;
        if (!done) begin
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL R7 out_valid actual %b expected %b", out_valid, ev);
            end
            checks++;
            if (out_taken !== et) begin
                errors++;
                if (ev)
                    $display("FAIL %s sel %0d flags %b actual %b expected %b",
                             req_of(esel), esel, eflg[3:0], out_taken, et);
                else
                    $display("FAIL R8 taken while invalid actual %b expected %b", out_taken, et);
            end
            if (ev && out_valid) begin
                res[esel][eflg] = out_taken;
                seen[esel][eflg] = 1;
            end
        end
    end

    task automatic drive(bit vld, int s, int f);
        @(negedge clk);
        in_valid = vld;
        cond_sel = 4'(s);
        {flag_n, flag_z, flag_v, flag_c} = 4'(f);
    endtask

    initial begin
        // R9: reset with strobe high and always selected
        drive(1, 8, 15);
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_taken !== 0) begin
            errors++;
            $display("FAIL R9 reset state actual %b%b expected 00", out_valid, out_taken);
        end
        rst_n = 1;

        // R2 R3 R4 R5 R6 R7: full sweep, back to back
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 16; f++)
                drive(1, s, f);

        // R8: idle cycles with always selected
        for (int f = 0; f < 4; f++) drive(0, 8, f);

        // Alternating strobe pattern
        for (int k = 0; k < 8; k++) drive(k % 2, 8 + k, k);
        drive(0, 0, 0);
        drive(0, 0, 0);

        // R9: mid-run reset while strobing
        drive(1, 8, 0);
        @(negedge clk);
        rst_n = 0;
        drive(1, 8, 0);
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_taken !== 0) begin
            errors++;
            $display("FAIL R9 mid-run reset actual %b%b expected 00", out_valid, out_taken);
        end
        rst_n = 1;
        drive(0, 0, 0);
        drive(0, 0, 0);

        // R1: complementary codes give opposite results
        for (int s = 0; s < 8; s++)
            for (int f = 0; f < 16; f++) begin
                checks++;
                if (!seen[s][f] || !seen[s+8][f] || res[s][f] == res[s+8][f]) begin
                    errors++;
                    $display("FAIL R1 sel %0d/%0d flags %0d actual %b/%b expected opposite",
                             s, s + 8, f, res[s][f], res[s+8][f]);
                end
            end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule